// File: doc/BRIEF.md
# Periodic Interrupt Down-Counter Timer

This block is a programmable periodic timer that counts down on a prescaled clock and raises an interrupt when it runs past zero. Software reaches it through three halfword registers: a control/status word, a modulus and a read-only view of the live count. The count advances once every 2^(code+1) system clocks. Here `code` is a 4-bit prescaler setting, and the fixed factor of two gives the half-rate count clock.

Each expiry sets a sticky flag and reloads the counter. In reload mode the counter restarts from the modulus. In free-running mode it restarts from the all-ones value. The interrupt pin is high whenever the flag and its enable are both set. Software can clear the flag, retune the modulus (optionally forcing the new value straight into the counter), and halt counting while a debug or low-power request is present.

The register port is a plain single-cycle write strobe with a combinational read mux. No data stream passes through the block, so there is no valid/ready pair.

Top module: `pit_timer`

## Requirements
- R1: After reset the control word reads 0x0000, the count reads 0x0000, the modulus reads 0xFFFF and `irq` is low.
- R2: Offset 0 selects the control word, offset 2 the modulus and offset 4 the count. A write to offset 4 leaves the count unchanged, and any other offset reads 0. In the control word, bit 0 is enable, bit 1 is reload mode, bit 2 is the flag, bit 3 is interrupt enable, bit 4 is overwrite, bit 5 is debug freeze, bit 6 is doze freeze, bits 11:8 are the prescaler code, and all other bits read 0.
- R3: While running, the count changes exactly once every 2^(code+1) clocks, where `code` is control bits 11:8.
- R4: `irq` is high exactly when the flag (bit 2) and interrupt enable (bit 3) are both 1.
- R5: With reload mode set, a count tick that finds the count at 0 loads the modulus and sets the flag. The period is therefore modulus+1 ticks.
- R6: With reload mode clear, a count tick at 0 loads 0xFFFF and sets the flag.
- R7: Writing 1 to bit 2 of the control word clears the flag, and writing 0 there leaves it as it is. An expiry in the same cycle as the clear wins, so the flag stays set.
- R8: A modulus write clears the flag, unless an expiry happens in the same cycle. If overwrite (bit 4) is 1, the written value enters the count on the next clock. Otherwise the count is untouched until the next reload.
- R9: A control write whose value differs from the current settings only in bits 2 and 3 neither reloads the count nor restarts the prescaler.
- R10: A control write that changes any of bits 0, 1, 4, 5, 6 or 11:8 restarts the prescaler and drops any tick due in that cycle. If the new enable is 1, the same write loads the count with the limit that the new mode selects.
- R11: While enable is 0, the count and the prescaler hold their values.
- R12: While (bit 5 and `dbg_halt`) or (bit 6 and `doze_req`) is true, the count and prescaler hold, and register writes still take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe, one write per cycle |
| reg_addr | input | 3 | Byte offset of the register |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr`, combinational |
| dbg_halt | input | 1 | Debug halt request |
| doze_req | input | 1 | Low-power doze request |
| irq | output | 1 | Interrupt request, flag AND enable |

## Verification
The bench builds the timer with its default parameters: a 16-bit count and a 4-bit prescaler code. It uses small moduli with prescaler codes 0 through 3, so many expiries fit in a few hundred cycles. Free-running wrap is reached by forcing a small count with an overwrite modulus write rather than waiting through 65536 ticks. That keeps reload, wrap, freeze, restart and same-cycle collisions all inside a short run while the full-width datapath is still in use.

// File: rtl/pit_pkg.sv
package pit_pkg;
  // control word bit positions (software-visible layout)
  localparam int BIT_EN    = 0;
  localparam int BIT_RLD   = 1;
  localparam int BIT_FLAG  = 2;
  localparam int BIT_IE    = 3;
  localparam int BIT_OVW   = 4;
  localparam int BIT_DBG   = 5;
  localparam int BIT_DOZE  = 6;
  localparam int PRE_LSB   = 8;

  // register offsets
  localparam int OFS_CTRL  = 0;
  localparam int OFS_MOD   = 2;
  localparam int OFS_CNT   = 4;

  typedef struct packed {
    logic doze_frz;
    logic dbg_frz;
    logic ovw;
    logic ie;
    logic rld;
    logic en;
  } mode_t;
endpackage

// File: rtl/pit_prescaler.sv
module pit_prescaler #(
  parameter int PRE_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic [PRE_W-1:0] code,
  output logic             tick
);
  localparam int DIV_W = (1 << PRE_W) + 1;

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] term;

  // last phase of a 2^(code+1) clock window
  assign term = (DIV_W'(2) << code) - DIV_W'(1);
  assign tick = run & ~restart & (div_q == term);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
    end else if (restart) begin
      div_q <= '0;
    end else if (run) begin
      div_q <= tick ? '0 : div_q + DIV_W'(1);
    end
  end
endmodule

// File: rtl/pit_counter.sv
module pit_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] reload_val,
  output logic [CNT_W-1:0] count,
  output logic             expire
);
  logic [CNT_W-1:0] cnt_q;

  assign count  = cnt_q;
  assign expire = tick & (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (tick) begin
      cnt_q <= expire ? reload_val : cnt_q - CNT_W'(1);
    end
  end
endmodule

// File: rtl/pit_regs.sv
module pit_regs
  import pit_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int PRE_W  = 4,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  wdata,
  input  logic              expire,
  input  logic [CNT_W-1:0]  count,
  output mode_t             mode,
  output logic [PRE_W-1:0]  pre,
  output logic              flag,
  output logic              reconfig,
  output logic              cnt_load,
  output logic [CNT_W-1:0]  cnt_load_val,
  output logic [CNT_W-1:0]  reload_val,
  output logic [CNT_W-1:0]  rdata
);
  logic [CNT_W-1:0] mod_q;
  mode_t            new_mode;
  logic [PRE_W-1:0] new_pre;
  logic             wr_ctrl, wr_mod;
  logic             cfg_change;

  assign wr_ctrl = wr & (addr == ADDR_W'(OFS_CTRL));
  assign wr_mod  = wr & (addr == ADDR_W'(OFS_MOD));

  always_comb begin
    new_mode.en       = wdata[BIT_EN];
    new_mode.rld      = wdata[BIT_RLD];
    new_mode.ie       = wdata[BIT_IE];
    new_mode.ovw      = wdata[BIT_OVW];
    new_mode.dbg_frz  = wdata[BIT_DBG];
    new_mode.doze_frz = wdata[BIT_DOZE];
  end
  assign new_pre = wdata[PRE_LSB +: PRE_W];

  // everything but the interrupt bits counts as a reconfiguration
  assign cfg_change = (new_pre != pre)
                    | (new_mode.en != mode.en) | (new_mode.rld != mode.rld)
                    | (new_mode.ovw != mode.ovw) | (new_mode.dbg_frz != mode.dbg_frz)
                    | (new_mode.doze_frz != mode.doze_frz);
  assign reconfig = wr_ctrl & cfg_change;

  assign reload_val   = mode.rld ? mod_q : '1;
  assign cnt_load     = (reconfig & new_mode.en) | (wr_mod & mode.ovw);
  assign cnt_load_val = wr_mod ? wdata : (new_mode.rld ? mod_q : '1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode  <= '0;
      pre   <= '0;
      mod_q <= '1;
      flag  <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        mode <= new_mode;
        pre  <= new_pre;
      end
      if (wr_mod) mod_q <= wdata;
      if (expire)
        flag <= 1'b1;
      else if (wr_mod || (wr_ctrl && wdata[BIT_FLAG]))
        flag <= 1'b0;
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      ADDR_W'(OFS_CTRL): begin
        rdata[BIT_EN]            = mode.en;
        rdata[BIT_RLD]           = mode.rld;
        rdata[BIT_FLAG]          = flag;
        rdata[BIT_IE]            = mode.ie;
        rdata[BIT_OVW]           = mode.ovw;
        rdata[BIT_DBG]           = mode.dbg_frz;
        rdata[BIT_DOZE]          = mode.doze_frz;
        rdata[PRE_LSB +: PRE_W]  = pre;
      end
      ADDR_W'(OFS_MOD): rdata = mod_q;
      ADDR_W'(OFS_CNT): rdata = count;
      default:          rdata = '0;
    endcase
  end
endmodule

// File: rtl/pit_timer.sv
module pit_timer
  import pit_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int PRE_W  = 4,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [CNT_W-1:0]  reg_wdata,
  output logic [CNT_W-1:0]  reg_rdata,
  input  logic              dbg_halt,
  input  logic              doze_req,
  output logic              irq
);
  mode_t            mode_q;
  logic [PRE_W-1:0] pre_q;
  logic             irq_flag;
  logic             reconfig;
  logic             cnt_load;
  logic [CNT_W-1:0] cnt_load_val;
  logic [CNT_W-1:0] reload_val;
  logic [CNT_W-1:0] cnt_value;
  logic             cnt_tick;
  logic             cnt_expire;
  logic             running;

  assign running = mode_q.en
                 & ~(mode_q.dbg_frz & dbg_halt)
                 & ~(mode_q.doze_frz & doze_req);

  pit_regs #(.CNT_W(CNT_W), .PRE_W(PRE_W), .ADDR_W(ADDR_W)) u_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr           (reg_wr),
    .addr         (reg_addr),
    .wdata        (reg_wdata),
    .expire       (cnt_expire),
    .count        (cnt_value),
    .mode         (mode_q),
    .pre          (pre_q),
    .flag         (irq_flag),
    .reconfig     (reconfig),
    .cnt_load     (cnt_load),
    .cnt_load_val (cnt_load_val),
    .reload_val   (reload_val),
    .rdata        (reg_rdata)
  );

  pit_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (running),
    .restart (reconfig),
    .code    (pre_q),
    .tick    (cnt_tick)
  );

  pit_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (cnt_tick),
    .load       (cnt_load),
    .load_val   (cnt_load_val),
    .reload_val (reload_val),
    .count      (cnt_value),
    .expire     (cnt_expire)
  );

  assign irq = mode_q.ie & irq_flag;
endmodule

// File: rtl/pit_timer_chk.sv
module pit_timer_chk
  import pit_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [CNT_W-1:0]  reg_wdata,
  input logic              dbg_halt,
  input logic              doze_req,
  input logic              tick,
  input logic [CNT_W-1:0]  count,
  input logic              flag,
  input mode_t             mode
);
  logic wr_cfg, at_zero;
  assign wr_cfg  = reg_wr & ((reg_addr == ADDR_W'(OFS_CTRL)) | (reg_addr == ADDR_W'(OFS_MOD)));
  assign at_zero = tick & (count == '0);

  a_r12_frozen_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode.dbg_frz && dbg_halt) || (mode.doze_frz && doze_req)) |-> !tick);

  a_r11_hold_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode.en && !wr_cfg) |=> $stable(count));

  a_r5_expiry_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    at_zero |=> flag);

  a_r7_zero_write_keeps_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == ADDR_W'(OFS_CTRL) && !reg_wdata[BIT_FLAG] && flag) |=> flag);

  a_r8_mod_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == ADDR_W'(OFS_MOD) && !at_zero) |=> !flag);

  a_r2_count_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == ADDR_W'(OFS_CNT) && !tick) |=> $stable(count));
endmodule

bind pit_timer pit_timer_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_wr    (reg_wr),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .dbg_halt  (dbg_halt),
  .doze_req  (doze_req),
  .tick      (cnt_tick),
  .count     (cnt_value),
  .flag      (irq_flag),
  .mode      (mode_q)
);

// File: tb/pit_timer_test.sv
`timescale 1ns/1ps
module pit_timer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [15:0] reg_wdata = 16'd0;
  logic [15:0] reg_rdata;
  logic        dbg_halt = 1'b0;
  logic        doze_req = 1'b0;
  logic        irq;

  always #2.5 clk = ~clk;

  pit_timer uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dbg_halt(dbg_halt),
    .doze_req(doze_req), .irq(irq)
  );

  int    errors = 0;
  int    checks = 0;
  bit    done = 0;
  string cur_tag = "R1";

  // behavioural reference state
  bit m_en, m_rld, m_flag, m_ie, m_ovw, m_dbg, m_doze;
  int m_pre, m_mod, m_cnt, m_div;

  function automatic int mread(input int a);
    case (a)
      0: return m_en | (m_rld << 1) | (m_flag << 2) | (m_ie << 3) | (m_ovw << 4)
              | (m_dbg << 5) | (m_doze << 6) | (m_pre << 8);
      2: return m_mod;
      4: return m_cnt;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin : model
    bit active, tick, expire, reconf;
    int nd, nc, wv, lim;
    if (!rst_n) begin
      {m_en, m_rld, m_flag, m_ie, m_ovw, m_dbg, m_doze} = '0;
      m_pre = 0; m_mod = 'hFFFF; m_cnt = 0; m_div = 0;
    end else begin
      wv = reg_wdata;
      active = m_en && !(m_dbg && dbg_halt) && !(m_doze && doze_req);
      reconf = reg_wr && reg_addr == 0 && ((wv & 'h0F73) != (mread(0) & 'h0F73));
      tick = active && !reconf && (m_div == (2 << m_pre) - 1);
      nd = reconf ? 0 : (active ? (tick ? 0 : m_div + 1) : m_div);
      expire = tick && m_cnt == 0;
      lim = m_rld ? m_mod : 'hFFFF;
      nc = m_cnt;
      if (tick) nc = expire ? lim : m_cnt - 1;
      if (reg_wr && reg_addr == 0) begin
        if (wv[2]) m_flag = 0;
        m_ie = wv[3];
        if (reconf) begin
          m_en = wv[0]; m_rld = wv[1]; m_ovw = wv[4]; m_dbg = wv[5]; m_doze = wv[6];
          m_pre = (wv >> 8) & 'hF;
          if (m_en) nc = m_rld ? m_mod : 'hFFFF;
        end
      end
      if (reg_wr && reg_addr == 2) begin
        m_flag = 0;
        if (m_ovw) nc = wv;
        m_mod = wv;
      end
      if (expire) m_flag = 1;
      m_cnt = nc;
      m_div = nd;
    end
  end

  task automatic check(input string what, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", cur_tag, what, act, exp, $time);
    end
  endtask

  // one cycle: compare the state left by the last edge, then drive the next access
  task automatic step(input bit we, input int a, input int d);
    @(negedge clk);
    check("rdata", int'(reg_rdata), mread(int'(reg_addr)));
    check("irq (R4)", int'(irq), int'(m_ie && m_flag));
    reg_wr    = we;
    reg_addr  = 3'(a);
    reg_wdata = 16'(d);
  endtask

  task automatic idle(input int n, input int a);
    for (int i = 0; i < n; i++) step(0, a, 0);
  endtask

  initial begin
    #(20000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cur_tag = "R1 reset values";
    step(0, 0, 0); step(0, 2, 0); step(0, 4, 0); step(0, 4, 0);
    cur_tag = "R2 unmapped offset";
    step(0, 6, 0); step(0, 4, 0);

    cur_tag = "R5 reload period";
    step(1, 2, 3); step(1, 0, 'h000B); idle(30, 4);
    cur_tag = "R7 write zero keeps flag";
    step(1, 0, 'h000B); idle(2, 0);
    cur_tag = "R7 write one clears flag";
    step(1, 0, 'h000F); idle(5, 0);
    cur_tag = "R9 interrupt-only write";
    step(1, 0, 'h0003); idle(3, 4); step(1, 0, 'h000B); idle(6, 4);

    cur_tag = "R3 prescaler code 2";
    step(1, 0, 'h020B); idle(60, 4);
    cur_tag = "R8 modulus without overwrite";
    step(1, 2, 6); idle(60, 4);
    cur_tag = "R8 modulus with overwrite";
    step(1, 0, 'h021B); idle(5, 4); step(1, 2, 2); idle(30, 4); step(0, 0, 0);

    cur_tag = "R6 free-run wrap";
    step(1, 0, 'h0019); step(1, 2, 4); idle(20, 4); step(0, 0, 0); idle(3, 0);

    cur_tag = "R2 count write ignored";
    step(1, 4, 'h1234); idle(2, 4); step(0, 0, 0); step(0, 2, 0);

    cur_tag = "R12 debug freeze";
    step(1, 0, 'h002B); dbg_halt = 1'b1; idle(12, 4);
    dbg_halt = 1'b0; idle(8, 4);
    cur_tag = "R12 doze freeze, writes live";
    step(1, 0, 'h005B); doze_req = 1'b1; idle(6, 4);
    step(1, 2, 9); idle(8, 4); step(0, 2, 0);
    doze_req = 1'b0; idle(25, 4);

    cur_tag = "R11 disabled hold";
    step(1, 0, 'h000A); idle(12, 4);
    cur_tag = "R10 reconfigure restarts";
    step(1, 0, 'h000B); idle(7, 4); step(1, 0, 'h010B); idle(30, 4);
    cur_tag = "R3 prescaler code 3";
    step(1, 2, 1); step(1, 0, 'h030B); idle(80, 4);
    cur_tag = "R7 clear at expiry";
    step(1, 2, 0); step(1, 0, 'h000B); idle(1, 4);
    for (int i = 0; i < 6; i++) step(1, 0, 'h000F);
    idle(4, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule